// File: doc/BRIEF.md
# Monopulse Sum and Difference Combiner

This block takes one complex baseband sample from each element of a 2x2 receive array at the same instant. Element A is top-left, B is top-right, C is bottom-left and D is bottom-right. It multiplies each sample by the complex conjugate of that element's steering weight. It then combines the four weighted samples into three channels. The sum channel adds all four elements. The azimuth difference channel subtracts the right column from the left column. The elevation difference channel subtracts the bottom row from the top row. A later estimator divides each difference channel by the sum channel to get the off-boresight angle.

All arithmetic is signed fixed point. Samples and weights are DW-bit two's complement values with DW-1 fraction bits. Each conjugate product is rounded to DW+2 bits. The channel outputs carry two more bits than the products, so no overflow can occur.

The four weights live in registers. A narrow write port changes them while samples keep streaming. After reset the weights point the array at 30 degrees azimuth and 20 degrees elevation.

Top module: `monopulse_combiner`

## Requirements
- R1: For each element, the weighted product is computed from the exact full-width values, with P_re = x_re*w_re + x_im*w_im and P_im = x_im*w_re - x_re*w_im. It is then rounded as floor((t + 2^14) / 2^15), which is round-half-up, to an 18-bit signed value.
- R2: sum = P_A + P_B + P_C + P_D, for the real and imaginary parts separately.
- R3: az = (P_A + P_C) - (P_B + P_D). A and C form the left column and B and D form the right column.
- R4: el = (P_A + P_B) - (P_C + P_D). A and B form the top row and C and D form the bottom row.
- R5: A sample captured at a rising edge with in_valid high appears on the outputs after the third rising edge, counting the capturing edge as the first. out_valid is high for exactly those cycles, and one result is produced for every accepted sample.
- R6: A write with wr_en high stores wr_re and wr_im into the weight selected by wr_sel (0 = A, 1 = B, 2 = C, 3 = D). The new weight applies to samples captured at later edges. A sample captured at the same edge as the write uses the old weight.
- R7: After reset the weights are A = (16055, -3268), B = (4773, 15673), C = (4773, -15673) and D = (16055, 3268), written as (real, imaginary).
- R8: During and after reset, out_valid is low and all channel outputs are zero. When no new result arrives, the outputs keep their last value, even while a weight is being written.
- R9: With every sample and weight at full-scale negative (-32768 in both parts), sum_re = 262144, and every other output is 0. The outputs do not wrap.
- R10: Samples may arrive on consecutive cycles, and each gives its own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies the four element samples |
| a_re | input | 16 | Element A sample, real part |
| a_im | input | 16 | Element A sample, imaginary part |
| b_re | input | 16 | Element B sample, real part |
| b_im | input | 16 | Element B sample, imaginary part |
| c_re | input | 16 | Element C sample, real part |
| c_im | input | 16 | Element C sample, imaginary part |
| d_re | input | 16 | Element D sample, real part |
| d_im | input | 16 | Element D sample, imaginary part |
| wr_en | input | 1 | Weight write strobe |
| wr_sel | input | 2 | Selects which element's weight is written |
| wr_re | input | 16 | Weight value written, real part |
| wr_im | input | 16 | Weight value written, imaginary part |
| out_valid | output | 1 | Qualifies the channel outputs |
| sum_re | output | 20 | Sum channel, real part |
| sum_im | output | 20 | Sum channel, imaginary part |
| az_re | output | 20 | Azimuth difference channel, real part |
| az_im | output | 20 | Azimuth difference channel, imaginary part |
| el_re | output | 20 | Elevation difference channel, real part |
| el_im | output | 20 | Elevation difference channel, imaginary part |

## Verification
A weight write and a sample capture can fall on the same rising edge. The bench provokes this by raising wr_en together with in_valid in the first slot of a two-sample burst, with the second sample following on the next cycle. The bench's own weight model applies the write only after it has computed the expected result for the first sample. The first result must therefore reflect the old weight and the second result the new one. Writes that arrive while no sample is flowing are also checked: the held outputs must not move.

// File: rtl/monopulse_combiner.sv
`timescale 1ns/1ps
module monopulse_combiner #(
  parameter int DW       = 16,
  parameter int DEF_A_RE = 16055,
  parameter int DEF_A_IM = -3268,
  parameter int DEF_B_RE = 4773,
  parameter int DEF_B_IM = 15673,
  parameter int DEF_C_RE = 4773,
  parameter int DEF_C_IM = -15673,
  parameter int DEF_D_RE = 16055,
  parameter int DEF_D_IM = 3268
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [15:0]   a_re,
  input  logic signed [15:0]   a_im,
  input  logic signed [15:0]   b_re,
  input  logic signed [15:0]   b_im,
  input  logic signed [15:0]   c_re,
  input  logic signed [15:0]   c_im,
  input  logic signed [15:0]   d_re,
  input  logic signed [15:0]   d_im,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic signed [15:0]   wr_re,
  input  logic signed [15:0]   wr_im,
  output logic                 out_valid,
  output logic signed [19:0]   sum_re,
  output logic signed [19:0]   sum_im,
  output logic signed [19:0]   az_re,
  output logic signed [19:0]   az_im,
  output logic signed [19:0]   el_re,
  output logic signed [19:0]   el_im
);
  localparam int FRAC = DW - 1;
  localparam int MW   = DW + 2;
  localparam int PW   = MW + 1;
  localparam int OW   = MW + 2;
  localparam int AW   = 2 * DW + 1;
  localparam int RND  = 1 << (FRAC - 1);
  localparam int PMAX = 1 << DW;

  logic signed [DW-1:0] x_re [4];
  logic signed [DW-1:0] x_im [4];
  logic signed [DW-1:0] w_re [4];
  logic signed [DW-1:0] w_im [4];

  assign x_re[0] = a_re;  assign x_im[0] = a_im;
  assign x_re[1] = b_re;  assign x_im[1] = b_im;
  assign x_re[2] = c_re;  assign x_im[2] = c_im;
  assign x_re[3] = d_re;  assign x_im[3] = d_im;

  // steering weight registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_re[0] <= DW'(DEF_A_RE);  w_im[0] <= DW'(DEF_A_IM);
      w_re[1] <= DW'(DEF_B_RE);  w_im[1] <= DW'(DEF_B_IM);
      w_re[2] <= DW'(DEF_C_RE);  w_im[2] <= DW'(DEF_C_IM);
      w_re[3] <= DW'(DEF_D_RE);  w_im[3] <= DW'(DEF_D_IM);
    end else if (wr_en) begin
      w_re[wr_sel] <= wr_re;
      w_im[wr_sel] <= wr_im;
    end
  end

  logic s1_v, s2_v;
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s2_v      <= 1'b0;
      out_valid <= 1'b0;
      since_rst <= '0;
    end else begin
      s1_v      <= in_valid;
      s2_v      <= s1_v;
      out_valid <= s2_v;
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end
  end

  // stage 1: conjugate multiply and round
  logic signed [MW-1:0] p_re [4];
  logic signed [MW-1:0] p_im [4];

  for (genvar g = 0; g < 4; g++) begin : g_cmul
    logic signed [AW-1:0] acc_re, acc_im;
    logic signed [MW-1:0] pr, pi;

    assign acc_re = AW'(x_re[g]) * AW'(w_re[g]) + AW'(x_im[g]) * AW'(w_im[g]);
    assign acc_im = AW'(x_im[g]) * AW'(w_re[g]) - AW'(x_re[g]) * AW'(w_im[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pr <= '0;
        pi <= '0;
      end else if (in_valid) begin
        pr <= MW'((acc_re + AW'(RND)) >>> FRAC);
        pi <= MW'((acc_im + AW'(RND)) >>> FRAC);
      end
    end

    assign p_re[g] = pr;
    assign p_im[g] = pi;

    AST_PROD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      s1_v |-> (pr <= PMAX && pr >= -PMAX && pi <= PMAX && pi >= -PMAX)); // R9
  end

  // stage 2: row sums and column-pair differences
  logic signed [PW-1:0] top_re, top_im, bot_re, bot_im;
  logic signed [PW-1:0] dtop_re, dtop_im, dbot_re, dbot_im;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_re  <= '0;  top_im  <= '0;
      bot_re  <= '0;  bot_im  <= '0;
      dtop_re <= '0;  dtop_im <= '0;
      dbot_re <= '0;  dbot_im <= '0;
    end else if (s1_v) begin
      top_re  <= PW'(p_re[0]) + PW'(p_re[1]);
      top_im  <= PW'(p_im[0]) + PW'(p_im[1]);
      bot_re  <= PW'(p_re[2]) + PW'(p_re[3]);
      bot_im  <= PW'(p_im[2]) + PW'(p_im[3]);
      dtop_re <= PW'(p_re[0]) - PW'(p_re[1]);
      dtop_im <= PW'(p_im[0]) - PW'(p_im[1]);
      dbot_re <= PW'(p_re[2]) - PW'(p_re[3]);
      dbot_im <= PW'(p_im[2]) - PW'(p_im[3]);
    end
  end

  // stage 3: channel outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_re <= '0;  sum_im <= '0;
      az_re  <= '0;  az_im  <= '0;
      el_re  <= '0;  el_im  <= '0;
    end else if (s2_v) begin
      sum_re <= OW'(top_re) + OW'(bot_re);
      sum_im <= OW'(top_im) + OW'(bot_im);
      el_re  <= OW'(top_re) - OW'(bot_re);
      el_im  <= OW'(top_im) - OW'(bot_im);
      az_re  <= OW'(dtop_re) + OW'(dbot_re);
      az_im  <= OW'(dtop_im) + OW'(dbot_im);
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_v |=> ($stable(sum_re) && $stable(sum_im) && $stable(az_re)
               && $stable(az_im) && $stable(el_re) && $stable(el_im))); // R8
  AST_SUM_EL_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sum_re[0] == el_re[0] && sum_im[0] == el_im[0])); // R4
  AST_SUM_AZ_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sum_re[0] == az_re[0] && sum_im[0] == az_im[0])); // R3
  AST_WR_SEL_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$isunknown(wr_sel)); // R6
endmodule

// File: tb/tb_monopulse_combiner.sv
`timescale 1ns/1ps
module tb_monopulse_combiner;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, in_valid, wr_en;
  logic [1:0] wr_sel;
  logic signed [15:0] a_re, a_im, b_re, b_im, c_re, c_im, d_re, d_im, wr_re, wr_im;
  logic out_valid;
  logic signed [19:0] sum_re, sum_im, az_re, az_im, el_re, el_im;

  monopulse_combiner dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .c_re(c_re), .c_im(c_im), .d_re(d_re), .d_im(d_im),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_re(wr_re), .wr_im(wr_im),
    .out_valid(out_valid),
    .sum_re(sum_re), .sum_im(sum_im), .az_re(az_re), .az_im(az_im),
    .el_re(el_re), .el_im(el_im));

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int wm_re [4];
  int wm_im [4];
  int bx_re [16][4];
  int bx_im [16][4];
  bit bw_en [16];
  int bw_sel [16];
  int bw_re [16];
  int bw_im [16];
  int ex [16][6];

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void cmul(int xr, int xi, int wr, int wi, output int pr, output int pi);
    longint t;
    t  = longint'(xr) * wr + longint'(xi) * wi;
    pr = int'((t + 64'sd16384) >>> 15);
    t  = longint'(xi) * wr - longint'(xr) * wi;
    pi = int'((t + 64'sd16384) >>> 15);
  endfunction

  function automatic void expect_slot(int n);
    int pr [4];
    int pi [4];
    for (int e = 0; e < 4; e++) cmul(bx_re[n][e], bx_im[n][e], wm_re[e], wm_im[e], pr[e], pi[e]);
    ex[n][0] = pr[0] + pr[1] + pr[2] + pr[3];
    ex[n][1] = pi[0] + pi[1] + pi[2] + pi[3];
    ex[n][2] = (pr[0] + pr[2]) - (pr[1] + pr[3]);
    ex[n][3] = (pi[0] + pi[2]) - (pi[1] + pi[3]);
    ex[n][4] = (pr[0] + pr[1]) - (pr[2] + pr[3]);
    ex[n][5] = (pi[0] + pi[1]) - (pi[2] + pi[3]);
    if (bw_en[n]) begin
      wm_re[bw_sel[n]] = bw_re[n];
      wm_im[bw_sel[n]] = bw_im[n];
    end
  endfunction

  task automatic idle_inputs();
    in_valid = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_re = '0; wr_im = '0;
    a_re = '0; a_im = '0; b_re = '0; b_im = '0;
    c_re = '0; c_im = '0; d_re = '0; d_im = '0;
  endtask

  task automatic drive_slot(int n);
    in_valid = 1'b1;
    a_re = 16'(bx_re[n][0]); a_im = 16'(bx_im[n][0]);
    b_re = 16'(bx_re[n][1]); b_im = 16'(bx_im[n][1]);
    c_re = 16'(bx_re[n][2]); c_im = 16'(bx_im[n][2]);
    d_re = 16'(bx_re[n][3]); d_im = 16'(bx_im[n][3]);
    wr_en = bw_en[n]; wr_sel = 2'(bw_sel[n]);
    wr_re = 16'(bw_re[n]); wr_im = 16'(bw_im[n]);
  endtask

  task automatic check_outputs(string req, int n);
    check("R5", {req, " out_valid"}, int'(out_valid), 1);
    check({req, " R2"}, "sum_re", int'(sum_re), ex[n][0]);
    check({req, " R2"}, "sum_im", int'(sum_im), ex[n][1]);
    check({req, " R3"}, "az_re", int'(az_re), ex[n][2]);
    check({req, " R3"}, "az_im", int'(az_im), ex[n][3]);
    check({req, " R4"}, "el_re", int'(el_re), ex[n][4]);
    check({req, " R4"}, "el_im", int'(el_im), ex[n][5]);
  endtask

  task automatic run_burst(int n, string req);
    for (int k = 0; k < n; k++) expect_slot(k);
    for (int cyc = 0; cyc < n + 4; cyc++) begin
      @(negedge clk);
      if (cyc >= 3 && cyc - 3 < n) check_outputs(req, cyc - 3);
      else if (cyc >= 3) check("R5", {req, " out_valid idle"}, int'(out_valid), 0);
      if (cyc < n) drive_slot(cyc);
      else idle_inputs();
    end
  endtask

  task automatic clear_slots();
    for (int n = 0; n < 16; n++) begin
      bw_en[n] = 1'b0; bw_sel[n] = 0; bw_re[n] = 0; bw_im[n] = 0;
      for (int e = 0; e < 4; e++) begin bx_re[n][e] = 0; bx_im[n][e] = 0; end
    end
  endtask

  task automatic write_weight(int sel, int wr, int wi);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_re = 16'(wr); wr_im = 16'(wi);
    @(negedge clk);
    idle_inputs();
    wm_re[sel] = wr; wm_im[sel] = wi;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R8", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "out_valid after reset", int'(out_valid), 0);
    check("R8", "sum_re after reset", int'(sum_re), 0);
    check("R8", "az_im after reset", int'(az_im), 0);
    check("R8", "el_re after reset", int'(el_re), 0);
  endtask

  task automatic t_defaults();
    wm_re = '{16055, 4773, 4773, 16055};
    wm_im = '{-3268, 15673, -15673, 3268};
    clear_slots();
    for (int e = 0; e < 4; e++) begin bx_re[0][e] = 10000; bx_im[0][e] = 0; end
    bx_re[1] = '{1200, -3400, 5600, -7800};
    bx_im[1] = '{-900, 2100, 30000, -32768};
    run_burst(2, "R7 defaults");
  endtask

  task automatic t_loaded_patterns();
    write_weight(0, 32767, 0);
    write_weight(1, 0, 32767);
    write_weight(2, -16384, 8192);
    write_weight(3, 12345, -23456);
    clear_slots();
    for (int n = 0; n < 4; n++)
      for (int e = 0; e < 4; e++) begin
        bx_re[n][e] = ((n * 7919 + e * 3001 + 11) % 65536) - 32768;
        bx_im[n][e] = ((n * 5413 + e * 9011 + 777) % 65536) - 32768;
      end
    run_burst(4, "R6 loaded weights");
  endtask

  task automatic t_rounding();
    write_weight(0, 16384, 0);
    write_weight(1, 16383, 0);
    write_weight(2, 16384, 0);
    write_weight(3, 0, 0);
    clear_slots();
    bx_re[0] = '{1, 1, -1, 0};
    run_burst(1, "R1 rounding");
    check("R1", "half rounds up", int'(sum_re), 1);
    check("R1", "below half rounds to zero", int'(az_re), 1);
  endtask

  task automatic t_fullscale();
    for (int e = 0; e < 4; e++) write_weight(e, -32768, -32768);
    clear_slots();
    for (int e = 0; e < 4; e++) begin bx_re[0][e] = -32768; bx_im[0][e] = -32768; end
    run_burst(1, "R9 full scale");
    check("R9", "sum_re full scale", int'(sum_re), 262144);
    check("R9", "sum_im full scale", int'(sum_im), 0);
  endtask

  task automatic t_back_to_back();
    write_weight(0, 23170, -23170);
    write_weight(1, -11000, 30000);
    write_weight(2, 32767, 32767);
    write_weight(3, -32768, 5);
    clear_slots();
    for (int n = 0; n < 12; n++)
      for (int e = 0; e < 4; e++) begin
        bx_re[n][e] = ((n * 12347 + e * 4099 + 3) % 65536) - 32768;
        bx_im[n][e] = ((n * 2027 + e * 15101 + 99) % 65536) - 32768;
      end
    run_burst(12, "R10 back to back");
  endtask

  task automatic t_same_cycle_write();
    write_weight(1, 32767, 0);
    clear_slots();
    for (int n = 0; n < 2; n++)
      for (int e = 0; e < 4; e++) begin bx_re[n][e] = 20000; bx_im[n][e] = -5000; end
    bw_en[0] = 1'b1; bw_sel[0] = 1; bw_re[0] = -16384; bw_im[0] = 16384;
    run_burst(2, "R6 write with sample");
    check("R6", "second sample uses new weight", int'(sum_re), ex[1][0]);
  endtask

  task automatic t_hold();
    int last [6];
    clear_slots();
    for (int e = 0; e < 4; e++) begin bx_re[0][e] = 3000 * (e + 1); bx_im[0][e] = -777 * e; end
    run_burst(1, "R8 hold setup");
    last = ex[0];
    write_weight(2, 111, -222);
    repeat (3) @(negedge clk);
    check("R8", "out_valid stays low", int'(out_valid), 0);
    check("R8", "sum_re held", int'(sum_re), last[0]);
    check("R8", "az_im held", int'(az_im), last[3]);
    check("R8", "el_re held", int'(el_re), last[4]);
  endtask

  initial begin
    t_reset();
    t_defaults();
    t_loaded_patterns();
    t_rounding();
    t_fullscale();
    t_back_to_back();
    t_same_cycle_write();
    t_hold();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule